// File: doc/BRIEF.md
# Two-Register Serial Control Slave with Status Readback

This block is the serial control port of a TV audio/video routing switch. It listens on a two-wire I2C bus as a slave and accepts a write transaction of two bytes: the first byte goes to control register 1 and the second to control register 2. Both registers drive parallel outputs that steer the analog switching. In a read transaction it returns two status bytes, which the surrounding logic supplies on parallel inputs.

The device answers one of two bus addresses. A strap input picks the address, so two switches can share one bus. SCL and SDA are brought into the system clock through a two-flop synchronizer. Edges, START and STOP are found on the synchronized levels. The block drives SDA only by pulling it low, through an enable output. A read may stop after either byte: the master ends it by not acknowledging a byte.

Top module: `avsw_i2c_slave`

## Requirements
- R1: While reset is high, and in the cycle after it, both control outputs are 0x00 and the SDA pull-down enable is low.
- R2: The address byte is matched on bits 7..2 = 100100 and bit 1 = strap, with bit 0 = 0 for a write and 1 for a read. With the strap low the write address is 0x90; with the strap high it is 0x92. A matching address is acknowledged by pulling SDA low during the ninth clock.
- R3: In a write, the first data byte (MSB first) is stored into control register 1 and the second into control register 2. Each is acknowledged in its ninth clock. A write that stops after one byte leaves control register 2 unchanged. Control outputs change only while SCL is low.
- R4: After an address that does not match, SDA is never pulled low and no control register changes until the next START.
- R5: A read returns status byte 1 and then, if the master acknowledges, status byte 2. Each byte is sent MSB first, with SDA valid while SCL is high.
- R6: A master NACK (SDA high in the ninth clock) after a read byte ends the read. SDA stays released until the next START.
- R7: A START seen at any point, including in the middle of an address or data byte, drops the transfer in progress without writing anything and begins a new address reception.
- R8: Status inputs are captured when the read address is accepted. Changes to them after that point do not alter the bytes returned in the same read.
- R9: The SDA pull-down enable turns on only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 1 | Address select strap (bit 1 of the address) |
| stat1_i | input | 8 | Status byte returned first in a read |
| stat2_i | input | 8 | Status byte returned second in a read |
| sda_low_o | output | 1 | When high, the pad pulls SDA low |
| ctl1_o | output | 8 | Control register 1 |
| ctl2_o | output | 8 | Control register 2 |

## Verification
The checks on timing assume that SCL stays low for far longer than the synchronizer delay, so that a pull-down which turns on a few cycles after a synchronized falling edge still falls in the raw low phase. The stimulus holds each SCL phase for twenty system clocks. It changes SDA only in the middle of the low phase, except when it forms START and STOP, and it never asserts a START while the slave could be pulling SDA low. The strap and the status inputs are changed only while the bus is idle, except in the one test that deliberately changes the status inputs during a read.

// File: rtl/avsw_i2c_pkg.sv
package avsw_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int NREG   = 2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADEC, ST_AACK,
    ST_WR, ST_WDEC, ST_WACK,
    ST_RD, ST_RREL, ST_RACK, ST_RNXT,
    ST_SKIP
  } link_st_t;
endpackage

// File: rtl/avsw_line_sync.sv
module avsw_line_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] pipe;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= {STAGES{RST_VAL}};
      last <= RST_VAL;
    end else begin
      pipe <= {pipe[STAGES-2:0], line_i};
      last <= pipe[STAGES-1];
    end
  end

  assign lvl_o  = pipe[STAGES-1];
  assign rise_o = pipe[STAGES-1] & ~last;
  assign fall_o = ~pipe[STAGES-1] & last;
endmodule

// File: rtl/avsw_link_fsm.sv
module avsw_link_fsm
  import avsw_i2c_pkg::*;
#(
  parameter int          W       = BYTE_W,
  parameter int          N       = NREG,
  parameter logic [5:0]  ADDR_HI = 6'b100100,
  localparam int         IDX_W   = (N > 1) ? $clog2(N) : 1,
  localparam int         CNT_W   = $clog2(W)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_lvl,
  input  logic                  scl_rise,
  input  logic                  scl_fall,
  input  logic                  sda_lvl,
  input  logic                  sda_rise,
  input  logic                  sda_fall,
  input  logic                  strap_i,
  input  logic [N-1:0][W-1:0]   stat_i,
  output logic                  sda_low_o,
  output logic                  wr_en_o,
  output logic [IDX_W-1:0]      wr_idx_o,
  output logic [W-1:0]          wr_data_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N - 1);

  link_st_t              st;
  logic [CNT_W-1:0]      cnt;
  logic [W-1:0]          sh;
  logic [W-1:0]          tx;
  logic [IDX_W-1:0]      idx;
  logic [IDX_W-1:0]      nidx;
  logic                  rnw;
  logic [N-1:0][W-1:0]   snap;
  logic                  start_ev;
  logic                  stop_ev;
  logic                  addr_hit;

  assign start_ev = scl_lvl & sda_fall;
  assign stop_ev  = scl_lvl & sda_rise;
  assign nidx     = idx + IDX_W'(1);
  assign addr_hit = (sh[W-1:2] == ADDR_HI) && (sh[1] == strap_i);

  always_ff @(posedge clk) begin
    wr_en_o <= 1'b0;
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      idx       <= '0;
      rnw       <= 1'b0;
      snap      <= '0;
      sda_low_o <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else if (start_ev) begin
      st        <= ST_ADDR;
      cnt       <= '0;
      idx       <= '0;
      sda_low_o <= 1'b0;
    end else if (stop_ev) begin
      st        <= ST_IDLE;
      sda_low_o <= 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_WR: if (scl_rise) begin
          sh  <= {sh[W-2:0], sda_lvl};
          cnt <= cnt + CNT_W'(1);
          if (cnt == LAST_BIT) st <= (st == ST_ADDR) ? ST_ADEC : ST_WDEC;
        end
        ST_ADEC: if (scl_fall) begin
          if (addr_hit) begin
            sda_low_o <= 1'b1;
            rnw       <= sh[0];
            snap      <= stat_i;
            st        <= ST_AACK;
          end else begin
            st <= ST_SKIP;
          end
        end
        ST_AACK: if (scl_fall) begin
          cnt <= '0;
          if (rnw) begin
            tx        <= snap[0];
            sda_low_o <= ~snap[0][W-1];
            st        <= ST_RD;
          end else begin
            sda_low_o <= 1'b0;
            st        <= ST_WR;
          end
        end
        ST_WDEC: if (scl_fall) begin
          wr_en_o   <= 1'b1;
          wr_idx_o  <= idx;
          wr_data_o <= sh;
          sda_low_o <= 1'b1;
          st        <= ST_WACK;
        end
        ST_WACK: if (scl_fall) begin
          sda_low_o <= 1'b0;
          cnt       <= '0;
          if (idx == IDX_LAST) st <= ST_SKIP;
          else begin
            idx <= nidx;
            st  <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            cnt <= cnt + CNT_W'(1);
            if (cnt == LAST_BIT) st <= ST_RREL;
          end else if (scl_fall) begin
            tx        <= {tx[W-2:0], 1'b0};
            sda_low_o <= ~tx[W-2];
          end
        end
        ST_RREL: if (scl_fall) begin
          sda_low_o <= 1'b0;
          st        <= ST_RACK;
        end
        ST_RACK: if (scl_rise) begin
          if (!sda_lvl && idx != IDX_LAST) begin
            idx <= nidx;
            tx  <= snap[nidx];
            st  <= ST_RNXT;
          end else begin
            st <= ST_SKIP;
          end
        end
        ST_RNXT: if (scl_fall) begin
          cnt       <= '0;
          sda_low_o <= ~tx[W-1];
          st        <= ST_RD;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/avsw_ctl_bank.sv
module avsw_ctl_bank
  import avsw_i2c_pkg::*;
#(
  parameter int  W     = BYTE_W,
  parameter int  N     = NREG,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [W-1:0]        wr_data_i,
  output logic [N-1:0][W-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                                     q_o[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))   q_o[g] <= wr_data_i;
    end
  end
endmodule

// File: rtl/avsw_i2c_slave.sv
module avsw_i2c_slave
  import avsw_i2c_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] ADDR_HI     = 6'b100100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              strap_i,
  input  logic [BYTE_W-1:0] stat1_i,
  input  logic [BYTE_W-1:0] stat2_i,
  output logic              sda_low_o,
  output logic [BYTE_W-1:0] ctl1_o,
  output logic [BYTE_W-1:0] ctl2_o
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic                       wr_en;
  logic [IDX_W-1:0]           wr_idx;
  logic [BYTE_W-1:0]          wr_data;
  logic [NREG-1:0][BYTE_W-1:0] regs;
  logic [NREG-1:0][BYTE_W-1:0] stat;

  assign stat = {stat2_i, stat1_i};

  avsw_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl (
    .clk(clk), .rst(rst), .line_i(scl_i),
    .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

  avsw_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda (
    .clk(clk), .rst(rst), .line_i(sda_i),
    .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

  avsw_link_fsm #(.W(BYTE_W), .N(NREG), .ADDR_HI(ADDR_HI)) u_fsm (
    .clk(clk), .rst(rst),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .strap_i(strap_i), .stat_i(stat),
    .sda_low_o(sda_low_o),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data));

  avsw_ctl_bank #(.W(BYTE_W), .N(NREG)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .q_o(regs));

  assign ctl1_o = regs[0];
  assign ctl2_o = regs[1];
endmodule

// File: rtl/avsw_i2c_slave_chk.sv
module avsw_i2c_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       sda_low_o,
  input logic [7:0] ctl1_o,
  input logic [7:0] ctl2_o
);
  // R1
  ctl_reset_chk: assert property (@(posedge clk)
    rst |=> (ctl1_o == 8'h00 && ctl2_o == 8'h00));

  // R1
  sda_reset_chk: assert property (@(posedge clk)
    rst |=> !sda_low_o);

  // R9
  sda_pull_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_low_o) |-> !scl_i);

  // R3
  ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable({ctl1_o, ctl2_o}) |-> !scl_i);
endmodule

bind avsw_i2c_slave avsw_i2c_slave_chk u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_low_o(sda_low_o),
  .ctl1_o(ctl1_o), .ctl2_o(ctl2_o));

// File: tb/tb_avsw_i2c_slave.sv
module tb_avsw_i2c_slave;
  localparam int H = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       strap = 1'b0;
  logic [7:0] st1 = 8'h00;
  logic [7:0] st2 = 8'h00;
  logic       sda_low;
  logic [7:0] ctl1, ctl2;
  logic       sda_line;

  assign sda_line = sda_m & ~sda_low;

  avsw_i2c_slave dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .strap_i(strap),
    .stat1_i(st1), .stat2_i(st2), .sda_low_o(sda_low),
    .ctl1_o(ctl1), .ctl2_o(ctl2));

  always #4 clk = ~clk;

  // reference model state, written only by the main process
  logic [7:0] exp1 = 8'h00, exp2 = 8'h00;
  logic       settle = 1'b1;

  // per-clock comparator, own counters
  int clk_chk = 0, clk_fail = 0;
  int oe_total = 0, edge_viol = 0;
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (sda_low) oe_total++;
      if (sda_low && !prev_oe && scl) edge_viol++;
      if (!settle) begin
        clk_chk++;
        if (ctl1 !== exp1 || ctl2 !== exp2) begin
          clk_fail++;
          $display("FAIL R3 clock compare: actual %h_%h expected %h_%h", ctl1, ctl2, exp1, exp2);
        end
      end
    end
    prev_oe = sda_low;
  end

  int n_chk = 0, n_fail = 0;

  task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hw(H); scl = 1'b1; hw(H); sda_m = 1'b0; hw(H); scl = 1'b0; hw(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hw(H); scl = 1'b1; hw(H); sda_m = 1'b1; hw(H);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; hw(H); scl = 1'b1; hw(H); scl = 1'b0; hw(1);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; hw(H); scl = 1'b1; hw(H/2); b = sda_line; hw(H/2); scl = 1'b0; hw(1);
  endtask

  task automatic send8(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic recv8(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
  endtask

  // write transaction with model update
  task automatic wr_txn(input logic [7:0] adr, input int nb, input logic [7:0] d0, input logic [7:0] d1);
    logic a, hit;
    int oe0;
    hit = (adr[7:1] == {6'b100100, strap}) && !adr[0];
    oe0 = oe_total;
    bus_start();
    send8(adr);
    recv_bit(a);
    check(a == !hit, hit ? "R2 address ack" : "R4 no ack on mismatch", {7'd0, a}, {7'd0, !hit});
    for (int k = 0; k < nb; k++) begin
      send8(k == 0 ? d0 : d1);
      settle = 1'b1; hw(6);
      if (hit && k == 0) exp1 = d0;
      if (hit && k == 1) exp2 = d1;
      settle = 1'b0;
      recv_bit(a);
      check(a == !hit, "R3 data ack", {7'd0, a}, {7'd0, !hit});
    end
    bus_stop();
    if (!hit) check(oe_total == oe0, "R4 sda untouched", 8'(oe_total - oe0), 8'd0);
  endtask

  // read transaction; optionally disturbs status inputs after the address ack
  task automatic rd_txn(input int nb, input logic [7:0] e1, input logic [7:0] e2, input logic disturb);
    logic a;
    logic [7:0] v;
    int oe0;
    bus_start();
    send8({6'b100100, strap, 1'b1});
    recv_bit(a);
    check(a == 1'b0, "R2 read address ack", {7'd0, a}, 8'd0);
    if (disturb) begin st1 = ~st1; st2 = ~st2; end
    for (int k = 0; k < nb; k++) begin
      recv8(v);
      check(v == (k == 0 ? e1 : e2), disturb ? "R8 latched status" : "R5 status byte", v, k == 0 ? e1 : e2);
      send_bit(k == nb - 1);
    end
    hw(4);
    oe0 = oe_total;
    check(!sda_low, "R6 released after NACK", {7'd0, sda_low}, 8'd0);
    for (int j = 0; j < 8; j++) send_bit(1'b1);
    check(oe_total == oe0, "R6 silent until START", 8'(oe_total - oe0), 8'd0);
    bus_stop();
  endtask

  task automatic run_all();
    logic a;
    hw(5);
    rst = 1'b0;
    hw(2);
    check(ctl1 == 8'h00, "R1 ctl1 reset", ctl1, 8'h00);
    check(ctl2 == 8'h00, "R1 ctl2 reset", ctl2, 8'h00);
    check(!sda_low, "R1 sda reset", {7'd0, sda_low}, 8'd0);
    settle = 1'b0;

    // R2 R3: strap low, address 0x90
    wr_txn(8'h90, 2, 8'hA5, 8'h3C);
    check(ctl1 == 8'hA5 && ctl2 == 8'h3C, "R3 both registers", ctl1, 8'hA5);
    // R4: wrong address for strap low
    wr_txn(8'h92, 2, 8'h11, 8'h22);
    check(ctl1 == 8'hA5, "R4 ctl1 kept", ctl1, 8'hA5);
    // R2: strap high, address 0x92
    strap = 1'b1; hw(4);
    wr_txn(8'h92, 2, 8'h5A, 8'hC3);
    check(ctl2 == 8'hC3, "R2 strap high write", ctl2, 8'hC3);
    wr_txn(8'h90, 1, 8'hFF, 8'h00);
    // R3: single byte then STOP
    wr_txn(8'h92, 1, 8'h81, 8'h00);
    check(ctl1 == 8'h81 && ctl2 == 8'hC3, "R3 one byte write", ctl2, 8'hC3);
    // R5: full read
    st1 = 8'h96; st2 = 8'h3E; hw(4);
    rd_txn(2, 8'h96, 8'h3E, 1'b0);
    // R6: read of first byte only
    st1 = 8'h4D; st2 = 8'hB2; hw(4);
    rd_txn(1, 8'h4D, 8'hB2, 1'b0);
    // R8: status inputs change during the read
    st1 = 8'hC9; st2 = 8'h17; hw(4);
    rd_txn(2, 8'hC9, 8'h17, 1'b1);
    // R7: repeated START inside an address byte
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    wr_txn(8'h92, 2, 8'h6B, 8'hD4);
    check(ctl1 == 8'h6B, "R7 restart in address", ctl1, 8'h6B);
    // R7: repeated START inside a data byte; partial byte not stored
    bus_start();
    send8(8'h92);
    recv_bit(a);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    settle = 1'b1; hw(6); settle = 1'b0;
    check(ctl1 == 8'h6B, "R7 partial byte dropped", ctl1, 8'h6B);
    wr_txn(8'h92, 2, 8'h0F, 8'hF0);
    check(ctl1 == 8'h0F && ctl2 == 8'hF0, "R7 restart in data", ctl2, 8'hF0);
    // R1: reset mid-life clears the registers
    settle = 1'b1;
    rst = 1'b1; hw(3); rst = 1'b0; hw(1);
    exp1 = 8'h00; exp2 = 8'h00;
    check(ctl1 == 8'h00 && ctl2 == 8'h00, "R1 reset clears", ctl1, 8'h00);
    settle = 1'b0;
    hw(10);
    check(edge_viol == 0, "R9 pull-down only in SCL low", 8'(edge_viol), 8'd0);
  endtask

  initial begin
    logic timed_out;
    timed_out = 1'b0;
    fork
      run_all();
      begin repeat (200000) @(posedge clk); timed_out = 1'b1; end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + clk_chk, n_fail + clk_fail);
    $finish;
  end
endmodule